// File: doc/BRIEF.md
# Luma/Chroma Horizontal Prefilter

This block is a horizontal low-pass stage that sits ahead of a video scaler. It takes one luminance sample and one chrominance sample per accepted pixel. The chrominance stream carries U and V interleaved, and every line starts with U. Each path has its own 2-bit kernel select. A select of zero passes the centre sample through unchanged. The other three values pick fixed symmetric kernels. The luma and chroma kernel sets are different.

Both paths run off one sliding window of eight registered samples plus the sample being accepted. The window centre sits four accepted samples back, so both paths and every mode share the same latency. When a kernel tap would reach past the start or end of the centre sample's line, it takes the nearest sample of that line instead. The chroma taps are two samples apart, so U is only ever filtered with U and V only with V. The kernel select is captured with each line's first sample and kept for the whole line.

Top module: `pf_prefilter`

## Requirements
- R1: While reset is asserted and after its release until results arrive, `px_out_valid` is 0 and both `y_out` and `uv_out` are 0.
- R2: Each accepted sample (`px_valid`=1) yields exactly one result, and results keep input order. The result for accepted sample n is presented, with `px_out_valid`=1 for one cycle, in the cycle after sample n+4 is accepted. Select 00 outputs the centre sample unchanged with this same latency, on either path.
- R3: Luma select 01 applies weights (1 2 1)/4 at sample offsets −1, 0, +1.
- R4: Luma select 10 applies weights (−4 4 7 18 7 4 −4)/32 at offsets −3..+3, which is the 7-tap kernel (−1 1 1.75 4.5 1.75 1 −1)/8.
- R5: Select 11 applies (1 2 2 2 1)/8 on both paths. The luma taps are at offsets −2..+2 and the chroma taps at −4, −2, 0, +2, +4.
- R6: Chroma select 01 applies (1 2 1)/4 at offsets −2, 0, +2, so U and V never mix.
- R7: Chroma select 10 applies (3 8 10 8 3)/32 at offsets −4, −2, 0, +2, +4.
- R8: A filtered result is floor((sum + 16)/32), where sum is the weighted sum at scale 32. Halves therefore round up. The result is then clamped to 0..255.
- R9: A tap that falls before a line's first sample or after its last takes the nearest sample of the same line, and for chroma the nearest sample of the same component. `px_line_start`=1 marks a line's first sample, and lines have even length.
- R10: The kernel selects are sampled only with the accepted line-start sample. Changes at any other time take effect at the next line start.
- R11: Cycles with `px_valid`=0 do not move the window and produce no result. The data, marker and select inputs are ignored in those cycles, and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| px_valid | input | 1 | Sample accept strobe |
| px_line_start | input | 1 | Marks the first sample of a line |
| y_in | input | 8 | Luminance sample |
| uv_in | input | 8 | Interleaved U/V sample |
| y_mode | input | 2 | Luma kernel select |
| uv_mode | input | 2 | Chroma kernel select |
| px_out_valid | output | 1 | Result strobe |
| y_out | output | 8 | Filtered luminance |
| uv_out | output | 8 | Filtered chrominance |

## Verification
The bench aims at line edges, using lines of only two and four samples. A design that mishandled edges would pull the previous or next line's pixels into the border results, or take a V sample into a U result. A line built so that the negative luma taps drive the sum below zero or above 255 exposes a design that wraps instead of clamping. Alternating 0/1 patterns expose truncation in place of round-half-up. The kernel select is moved on every sample after each line start and randomised in idle cycles, and idle cycles also raise the line-start marker. A design that picked up the select mid-line, or that advanced or reacted in idle cycles, would then produce results computed with the wrong kernel or shifted by a sample.

// File: rtl/pf_prefilter_pkg.sv
package pf_prefilter_pkg;

    // kernels are held at a common scale of 2**KNORM
    localparam int KNORM = 5;

    typedef enum logic [1:0] {
        KSEL_PASS  = 2'b00,
        KSEL_SOFT  = 2'b01,
        KSEL_SHAPE = 2'b10,
        KSEL_WIDE  = 2'b11
    } ksel_e;

    // luma weight at sample offset off (stride 1), scale 32
    function automatic int luma_weight(ksel_e k, int off);
        int a;
        a = (off < 0) ? -off : off;
        case (k)
            KSEL_SOFT:  return (a == 0) ? 16 : (a == 1) ? 8 : 0;
            KSEL_SHAPE: return (a == 0) ? 18 : (a == 1) ? 7 : (a == 2) ? 4 : (a == 3) ? -4 : 0;
            KSEL_WIDE:  return (a <= 1) ? 8 : (a == 2) ? 4 : 0;
            default:    return 0;
        endcase
    endfunction

    // chroma weight at same-component offset off (stride 2), scale 32
    function automatic int chroma_weight(ksel_e k, int off);
        int a;
        a = (off < 0) ? -off : off;
        case (k)
            KSEL_SOFT:  return (a == 0) ? 16 : (a == 1) ? 8 : 0;
            KSEL_SHAPE: return (a == 0) ? 10 : (a == 1) ? 8 : (a == 2) ? 3 : 0;
            KSEL_WIDE:  return (a <= 1) ? 8 : (a == 2) ? 4 : 0;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/pf_window.sv
module pf_window #(
    parameter int DW    = 8,
    parameter int REACH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_first,
    input  logic [DW-1:0]              y_in,
    input  logic [DW-1:0]              c_in,
    input  logic [1:0]                 ysel_cfg,
    input  logic [1:0]                 csel_cfg,
    output logic [2*REACH:0][DW-1:0]   y_win,
    output logic [2*REACH:0][DW-1:0]   c_win,
    output logic [2*REACH:0]           first_win,
    output logic [2*REACH:0]           live_win,
    output logic [1:0]                 ysel_mid,
    output logic [1:0]                 csel_mid
);
    localparam int SLOTS = 2 * REACH;

    typedef struct packed {
        logic [SLOTS-1:0][DW-1:0] y;
        logic [SLOTS-1:0][DW-1:0] c;
        logic [SLOTS-1:0]         first;
        logic [SLOTS-1:0]         live;
        logic [SLOTS-1:0][1:0]    ysel;
        logic [SLOTS-1:0][1:0]    csel;
        logic [1:0]               yhold;
        logic [1:0]               chold;
    } win_t;

    win_t st_d, st_q;
    logic [1:0] ysel_now, csel_now;

    always_comb begin
        st_d     = st_q;
        ysel_now = in_first ? ysel_cfg : st_q.yhold;
        csel_now = in_first ? csel_cfg : st_q.chold;
        if (in_valid) begin
            st_d.y     = {st_q.y[SLOTS-2:0], y_in};
            st_d.c     = {st_q.c[SLOTS-2:0], c_in};
            st_d.first = {st_q.first[SLOTS-2:0], in_first};
            st_d.live  = {st_q.live[SLOTS-2:0], 1'b1};
            st_d.ysel  = {st_q.ysel[SLOTS-2:0], ysel_now};
            st_d.csel  = {st_q.csel[SLOTS-2:0], csel_now};
            st_d.yhold = ysel_now;
            st_d.chold = csel_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // slot 0 is the sample being offered, higher slots are older
    assign y_win     = {st_q.y, y_in};
    assign c_win     = {st_q.c, c_in};
    assign first_win = {st_q.first, in_first};
    assign live_win  = {st_q.live, 1'b1};
    assign ysel_mid  = st_q.ysel[REACH-1];
    assign csel_mid  = st_q.csel[REACH-1];

endmodule

// File: rtl/pf_edge_fill.sv
module pf_edge_fill #(
    parameter int DW     = 8,
    parameter int REACH  = 4,
    parameter int STRIDE = 1
) (
    input  logic [2*REACH:0][DW-1:0] win,
    input  logic [2*REACH:0]         first_win,
    input  logic [2*REACH:0]         live_win,
    output logic [2*REACH:0][DW-1:0] taps
);
    logic cut_new, cut_old;

    always_comb begin
        taps    = win;
        // newer side: a line start between centre and slot j cuts slot j off
        cut_new = 1'b0;
        for (int j = REACH - 1; j >= 0; j--) begin
            cut_new = cut_new | first_win[j];
            if (cut_new) begin
                taps[j] = taps[(j + STRIDE <= REACH) ? j + STRIDE : REACH];
            end
        end
        // older side: centre or anything newer than slot j opened a line
        cut_old = 1'b0;
        for (int j = REACH + 1; j <= 2 * REACH; j++) begin
            cut_old = cut_old | first_win[j-1] | ~live_win[j];
            if (cut_old) begin
                taps[j] = taps[(j - STRIDE >= REACH) ? j - STRIDE : REACH];
            end
        end
    end

endmodule

// File: rtl/pf_fir.sv
module pf_fir
    import pf_prefilter_pkg::*;
#(
    parameter int DW     = 8,
    parameter int REACH  = 4,
    parameter int STRIDE = 1,
    parameter bit CHROMA = 1'b0
) (
    input  logic [2*REACH:0][DW-1:0] taps,
    input  logic [1:0]               sel,
    output logic [DW-1:0]            res
);
    localparam int HALF  = REACH / STRIDE;
    localparam int ACC_W = DW + 8;
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << DW) - 1);
    localparam logic signed [ACC_W-1:0] BIAS = ACC_W'(1 << (KNORM - 1));

    logic [2*HALF:0][7:0] wt;

    for (genvar o = 0; o <= 2 * HALF; o++) begin : g_wt
        if (CHROMA) begin : g_c
            assign wt[o] = 8'(chroma_weight(ksel_e'(sel), o - HALF));
        end else begin : g_y
            assign wt[o] = 8'(luma_weight(ksel_e'(sel), o - HALF));
        end
    end

    logic signed [ACC_W-1:0] acc, biased, scaled;

    always_comb begin
        acc = '0;
        for (int o = 0; o <= 2 * HALF; o++) begin
            acc = acc + ACC_W'($signed(wt[o]))
                      * $signed({{(ACC_W-DW){1'b0}}, taps[REACH + (o - HALF) * STRIDE]});
        end
        biased = acc + BIAS;
        scaled = biased >>> KNORM;
        if (ksel_e'(sel) == KSEL_PASS) begin
            res = taps[REACH];
        end else if (scaled < 0) begin
            res = '0;
        end else if (scaled > MAXV) begin
            res = '1;
        end else begin
            res = scaled[DW-1:0];
        end
    end

endmodule

// File: rtl/pf_prefilter.sv
module pf_prefilter #(
    parameter int DW    = 8,
    parameter int REACH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          px_valid,
    input  logic          px_line_start,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] uv_in,
    input  logic [1:0]    y_mode,
    input  logic [1:0]    uv_mode,
    output logic          px_out_valid,
    output logic [DW-1:0] y_out,
    output logic [DW-1:0] uv_out
);
    localparam int Y_STRIDE = 1;
    localparam int C_STRIDE = 2;

    logic [2*REACH:0][DW-1:0] y_win, c_win, y_taps, c_taps;
    logic [2*REACH:0]         first_win, live_win;
    logic [1:0]               ysel_mid, csel_mid;
    logic [DW-1:0]            y_res, c_res;

    pf_window #(.DW(DW), .REACH(REACH)) i_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (px_valid),
        .in_first  (px_line_start),
        .y_in      (y_in),
        .c_in      (uv_in),
        .ysel_cfg  (y_mode),
        .csel_cfg  (uv_mode),
        .y_win     (y_win),
        .c_win     (c_win),
        .first_win (first_win),
        .live_win  (live_win),
        .ysel_mid  (ysel_mid),
        .csel_mid  (csel_mid)
    );

    pf_edge_fill #(.DW(DW), .REACH(REACH), .STRIDE(Y_STRIDE)) i_yfill (
        .win (y_win), .first_win (first_win), .live_win (live_win), .taps (y_taps)
    );

    pf_edge_fill #(.DW(DW), .REACH(REACH), .STRIDE(C_STRIDE)) i_cfill (
        .win (c_win), .first_win (first_win), .live_win (live_win), .taps (c_taps)
    );

    pf_fir #(.DW(DW), .REACH(REACH), .STRIDE(Y_STRIDE), .CHROMA(1'b0)) i_yfir (
        .taps (y_taps), .sel (ysel_mid), .res (y_res)
    );

    pf_fir #(.DW(DW), .REACH(REACH), .STRIDE(C_STRIDE), .CHROMA(1'b1)) i_cfir (
        .taps (c_taps), .sel (csel_mid), .res (c_res)
    );

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] y;
        logic [DW-1:0] c;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d       = o_q;
        o_d.valid = px_valid & live_win[REACH];
        if (o_d.valid) begin
            o_d.y = y_res;
            o_d.c = c_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign px_out_valid = o_q.valid;
    assign y_out        = o_q.y;
    assign uv_out       = o_q.c;

endmodule

// File: rtl/pf_prefilter_chk.sv
module pf_prefilter_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          px_valid,
    input logic          px_out_valid,
    input logic [DW-1:0] y_out,
    input logic [DW-1:0] uv_out
);
    // accepted samples not yet answered
    logic [3:0] lag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lag_q <= '0;
        end else begin
            lag_q <= lag_q + {3'b0, px_valid} - {3'b0, px_out_valid};
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!px_out_valid && y_out == '0 && uv_out == '0));

    p_result_needs_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        px_out_valid |-> $past(px_valid));

    p_result_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        px_out_valid |-> (lag_q == 4'd5));

    p_lag_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lag_q <= 4'd5);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !px_out_valid |-> ($stable(y_out) && $stable(uv_out)));

endmodule

bind pf_prefilter pf_prefilter_chk #(.DW(DW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .px_valid     (px_valid),
    .px_out_valid (px_out_valid),
    .y_out        (y_out),
    .uv_out       (uv_out)
);

// File: tb/test_pf_prefilter.sv
module test_pf_prefilter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       px_valid = 1'b0;
    logic       px_line_start = 1'b0;
    logic [7:0] y_in = '0;
    logic [7:0] uv_in = '0;
    logic [1:0] y_mode = '0;
    logic [1:0] uv_mode = '0;
    logic       px_out_valid;
    logic [7:0] y_out, uv_out;

    always #10 clk = ~clk;

    pf_prefilter i_pf_prefilter (
        .clk (clk), .rst_n (rst_n), .px_valid (px_valid), .px_line_start (px_line_start),
        .y_in (y_in), .uv_in (uv_in), .y_mode (y_mode), .uv_mode (uv_mode),
        .px_out_valid (px_out_valid), .y_out (y_out), .uv_out (uv_out)
    );

    typedef struct {
        int y;
        int c;
        int yt;
        int ct;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         bad = 0;
    bit         done = 1'b0;
    logic [31:0] lcg = 32'h1234_5678;

    function int rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return int'(lcg[23:16]);
    endfunction

    function automatic string tname(int n);
        case (n)
            1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
            5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
            9: return "R9";   10: return "R10"; 11: return "R11";
            default: return "R?";
        endcase
    endfunction

    // weights at scale 32 straight from R3..R7
    function automatic int yw(int m, int off);
        int a = (off < 0) ? -off : off;
        if (m == 1) return (a == 0) ? 16 : (a == 1) ? 8 : 0;
        if (m == 2) return (a == 0) ? 18 : (a == 1) ? 7 : (a == 2) ? 4 : (a == 3) ? -4 : 0;
        if (m == 3) return (a <= 1) ? 8 : (a == 2) ? 4 : 0;
        return 0;
    endfunction

    function automatic int cw(int m, int off);
        int a = (off < 0) ? -off : off;
        if (m == 1) return (a == 0) ? 16 : (a == 1) ? 8 : 0;
        if (m == 2) return (a == 0) ? 10 : (a == 1) ? 8 : (a == 2) ? 3 : 0;
        if (m == 3) return (a <= 1) ? 8 : (a == 2) ? 4 : 0;
        return 0;
    endfunction

    // R8: round half up, clamp
    function automatic int norm(int s);
        int v;
        if (s + 16 < 0) return 0;
        v = (s + 16) / 32;
        return (v > 255) ? 255 : v;
    endfunction

    task automatic check(int tag, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tname(tag), what, act, expv);
        end
    endtask

    // driver: builds one line, queues its expected results, then drives it
    task automatic send_line(int len, int ym, int cm, int pat, int tag, int gapmax, bit keep);
        int ya[64];
        int ca[64];
        for (int i = 0; i < len; i++) begin
            case (pat)
                1: ya[i] = (i == 0 || i == 6 || (i >= 8 && i <= 12)) ? 255 : 0;
                2: ya[i] = i % 2;
                3: ya[i] = (i * 16) % 256;
                default: ya[i] = rnd();
            endcase
            ca[i] = (pat == 2) ? ((i / 2) % 2) : rnd();
        end
        if (keep) begin
            for (int i = 0; i < len; i++) begin
                exp_t e;
                int sy = 0;
                int sc = 0;
                for (int d = -3; d <= 3; d++) begin
                    int k = i + d;
                    if (k < 0) k = 0;
                    if (k > len - 1) k = len - 1;
                    sy += yw(ym, d) * ya[k];
                end
                for (int d = -2; d <= 2; d++) begin
                    int k = i + 2 * d;
                    while (k < 0) k += 2;
                    while (k > len - 1) k -= 2;
                    sc += cw(cm, d) * ca[k];
                end
                e.y  = (ym == 0) ? ya[i] : norm(sy);
                e.c  = (cm == 0) ? ca[i] : norm(sc);
                e.yt = (tag != 0) ? tag : (ym == 0) ? 2 : (ym == 1) ? 3 : (ym == 2) ? 4 : 5;
                e.ct = (tag != 0) ? tag : (cm == 0) ? 2 : (cm == 1) ? 6 : (cm == 2) ? 7 : 5;
                sb.push_back(e);
            end
        end
        for (int i = 0; i < len; i++) begin
            int gaps = (gapmax > 0) ? (rnd() % (gapmax + 1)) : ((rnd() % 4 == 0) ? 1 : 0);
            repeat (gaps) begin
                @(negedge clk);
                px_valid      = 1'b0;
                px_line_start = 1'b1;          // R11: marker ignored when idle
                y_in          = 8'(rnd());
                uv_in         = 8'(rnd());
                y_mode        = 2'(rnd());
                uv_mode       = 2'(rnd());
            end
            @(negedge clk);
            px_valid      = 1'b1;
            px_line_start = (i == 0);
            y_in          = 8'(ya[i]);
            uv_in         = 8'(ca[i]);
            // R10: selects move after the line start
            y_mode        = (i == 0) ? 2'(ym) : 2'(ym + 1 + i);
            uv_mode       = (i == 0) ? 2'(cm) : 2'(cm + 3 + i);
        end
        @(negedge clk);
        px_valid      = 1'b0;
        px_line_start = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && px_out_valid && !done) begin
            if (sb.size() == 0) begin
                check(2, "unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.yt, "luma", int'(y_out), e.y);
                check(e.ct, "chroma", int'(uv_out), e.c);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1, "valid in reset", int'(px_out_valid), 0);
        check(1, "y_out in reset", int'(y_out), 0);
        check(1, "uv_out in reset", int'(uv_out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(1, "valid after reset", int'(px_out_valid), 0);
        check(1, "y_out after reset", int'(y_out), 0);

        send_line(16, 0, 0, 0, 0, 0, 1);   // R2 bypass both paths
        send_line(20, 1, 1, 0, 0, 0, 1);   // R3, R6
        send_line(24, 2, 2, 0, 0, 0, 1);   // R4, R7
        send_line(12, 3, 3, 3, 0, 0, 1);   // R5
        send_line(16, 2, 1, 1, 8, 0, 1);   // R8 clamp both ends
        send_line(12, 1, 1, 2, 8, 0, 1);   // R8 halves round up
        send_line(2,  2, 2, 0, 9, 0, 1);   // R9 shortest line
        send_line(4,  3, 2, 0, 9, 0, 1);   // R9
        send_line(6,  1, 3, 0, 9, 0, 1);   // R9
        send_line(10, 1, 2, 0, 10, 0, 1);  // R10 select moves mid-line
        send_line(10, 3, 0, 0, 10, 0, 1);  // R10
        send_line(16, 2, 1, 0, 11, 3, 1);  // R11 heavy idle gaps
        send_line(8,  0, 3, 0, 0, 0, 1);   // R2 bypass after filtering
        send_line(4,  0, 0, 3, 0, 0, 0);   // trailing line pushes the tail out

        repeat (12) @(negedge clk);
        check(2, "results outstanding", sb.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule